// File: doc/BRIEF.md
# Region-Decoding Prioritized Bus Arbiter

This block sits between three internal request sources (core data, instruction/vector fetch and debug) and three destination ports. Each source presents a request flag and a 32-bit address. The block decodes the address into one of three fixed windows: a code window, a system window or an external peripheral window. It then picks one requester per port by a fixed priority. The address and the winning source identifier go into a registered ready/valid slave port.

A source that loses arbitration sees its wait output high. It keeps its request and address unchanged until wait drops, and the request is taken in the cycle that wait is low. The port accepts a new request only while it is idle or in the cycle its current transfer completes (valid and ready both high). A granted transfer therefore stays on the port until the slave takes it. Sources that target different ports are served in the same cycle.

An address that falls in the unmapped window, or a fetch aimed at a window that fetches may not use, is not sent to any port. It is answered with a one-cycle error pulse.

Top module: `bus_region_arbiter`

## Requirements
- R1: Source encoding is data = 0, fetch = 1, debug = 2, and port source fields use the same encoding. A data or debug request with an address from 0x00000000 to 0x1FFFFFFF is routed to the code port, with the full address on code_addr.
- R2: A request from any source with an address from 0x20000000 to 0xDFFFFFFF, or from 0xE0100000 to 0xFFFFFFFF, is routed to the system port, with the full address on sys_addr.
- R3: A data or debug request with an address from 0xE0040000 to 0xE00FFFFF is routed to the peripheral port, and only address bits [19:0] appear on per_addr.
- R4: A request with an address from 0xE0000000 to 0xE003FFFF is not routed to any port, and neither is a fetch request into the code or peripheral window. The wait output of that source is low in the request cycle, and its err output is high for exactly the next cycle.
- R5: When the system port can accept, data wins over fetch, and fetch wins over debug.
- R6: On the code and peripheral ports, data wins over debug whenever both request at once.
- R7: A routed request that does not win has its wait output high. It is accepted, with wait low, in the first cycle it is the highest-priority requester of a port that can accept.
- R8: While a port shows valid with ready low, valid, address and source stay unchanged, and no other request is accepted on that port.
- R9: A port can accept while idle or in a cycle with valid and ready both high. The accepted address and source appear on the port one cycle later, so back-to-back transfers lose no cycle.
- R10: Requests to different ports are accepted in the same cycle.
- R11: After reset, every port's valid and every err output are low.
- R12: A continuous stream of data requests to a port keeps a debug request to that port waiting. The debug request is accepted in the first cycle in which no data request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 3 | Request flag per source (bit 0 data, 1 fetch, 2 debug) |
| src_addr | input | 3x32 | Address per source |
| src_wait | output | 3 | Request is pending and must be held |
| src_err | output | 3 | One-cycle error response for an unroutable request |
| code_valid | output | 1 | Code port holds a transfer |
| code_addr | output | 32 | Code port address |
| code_src | output | 2 | Source owning the code transfer |
| code_ready | input | 1 | Code slave takes the transfer |
| sys_valid | output | 1 | System port holds a transfer |
| sys_addr | output | 32 | System port address |
| sys_src | output | 2 | Source owning the system transfer |
| sys_ready | input | 1 | System slave takes the transfer |
| per_valid | output | 1 | Peripheral port holds a transfer |
| per_addr | output | 20 | Peripheral port address, low bits only |
| per_src | output | 2 | Source owning the peripheral transfer |
| per_ready | input | 1 | Peripheral slave takes the transfer |

## Verification
Wait is combinational, so the bench samples it one time unit after driving the inputs on the falling edge, before the next rising edge. Port valid, address and source, and the err pulse, are due one rising edge after acceptance, and the bench reads them on the following falling edge. The sweep uses every request pattern across boundary addresses of all windows for every source. Between combinations it spends one idle cycle with all ready inputs high, so each combination starts on empty ports. The hold and starvation runs step one cycle at a time and check wait and port outputs in the same two sample slots.

// File: rtl/bra_pkg.sv
package bra_pkg;
  localparam int NSRC = 3;
  localparam int SW   = 2;

  typedef enum logic [1:0] {
    SRC_DATA  = 2'd0,
    SRC_FETCH = 2'd1,
    SRC_DEBUG = 2'd2
  } src_e;

  // Address windows (32-bit space)
  localparam logic [31:0] CODE_END  = 32'h2000_0000; // code: below this
  localparam logic [31:0] HOLE_LO   = 32'hE000_0000; // unmapped start
  localparam logic [31:0] PER_LO    = 32'hE004_0000; // peripheral start
  localparam logic [31:0] PER_END   = 32'hE010_0000; // peripheral end (excl)
endpackage

// File: rtl/bra_region_dec.sv
module bra_region_dec
  import bra_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter bit IS_FETCH = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              to_code,
  output logic              to_sys,
  output logic              to_per,
  output logic              to_err
);
  logic in_code, in_hole, in_per;

  always_comb begin
    in_code = (addr < CODE_END);
    in_hole = (addr >= HOLE_LO) && (addr < PER_LO);
    in_per  = (addr >= PER_LO) && (addr < PER_END);
    to_code = in_code && !IS_FETCH;
    to_per  = in_per && !IS_FETCH;
    to_sys  = !in_code && !in_hole && !in_per;
    to_err  = in_hole || (IS_FETCH && (in_code || in_per));
  end
endmodule

// File: rtl/bra_err_resp.sv
module bra_err_resp #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] bad,
  output logic [NSRC-1:0] err
);
  always_ff @(posedge clk) begin
    if (rst) err <= '0;
    else     err <= bad;
  end
endmodule

// File: rtl/bra_port_arb.sv
module bra_port_arb #(
  parameter int NSRC   = 3,
  parameter int SW     = 2,
  parameter int OUT_AW = 32,
  parameter logic [NSRC-1:0][SW-1:0] PRIO = {2'd2, 2'd1, 2'd0}
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NSRC-1:0]              req,
  input  logic [NSRC-1:0][OUT_AW-1:0]  addr,
  input  logic                         ready,
  output logic [NSRC-1:0]              gnt,
  output logic                         valid,
  output logic [OUT_AW-1:0]            out_addr,
  output logic [SW-1:0]                out_src
);
  logic          can_acc;
  logic          found;
  logic [SW-1:0] win;

  assign can_acc = !valid || ready;

  // PRIO[0] is the highest-priority source index
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (!found && can_acc && req[PRIO[k]]) begin
        gnt[PRIO[k]] = 1'b1;
        win          = PRIO[k];
        found        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      out_addr <= '0;
      out_src  <= '0;
    end else if (can_acc) begin
      valid <= found;
      if (found) begin
        out_addr <= addr[win];
        out_src  <= win;
      end
    end
  end

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(out_addr) && $stable(out_src));

  assert_no_grant_busy_R8: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |-> gnt == '0);

  assert_grant_shows_R9: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |=> valid);

  assert_top_prio_R5_R6: assert property (@(posedge clk) disable iff (rst)
    can_acc && req[PRIO[0]] |-> gnt[PRIO[0]]);

  assert_second_prio_R5: assert property (@(posedge clk) disable iff (rst)
    can_acc && !req[PRIO[0]] && req[PRIO[1]] |-> gnt[PRIO[1]]);
endmodule

// File: rtl/bus_region_arbiter.sv
module bus_region_arbiter
  import bra_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PER_AW = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [2:0]                   src_req,
  input  logic [2:0][ADDR_W-1:0]       src_addr,
  output logic [2:0]                   src_wait,
  output logic [2:0]                   src_err,
  output logic                         code_valid,
  output logic [ADDR_W-1:0]            code_addr,
  output logic [1:0]                   code_src,
  input  logic                         code_ready,
  output logic                         sys_valid,
  output logic [ADDR_W-1:0]            sys_addr,
  output logic [1:0]                   sys_src,
  input  logic                         sys_ready,
  output logic                         per_valid,
  output logic [PER_AW-1:0]            per_addr,
  output logic [1:0]                   per_src,
  input  logic                         per_ready
);
  logic [NSRC-1:0] to_code, to_sys, to_per, to_err;
  logic [NSRC-1:0] code_req, sys_req, per_req, bad;
  logic [NSRC-1:0] code_gnt, sys_gnt, per_gnt;
  logic [NSRC-1:0][PER_AW-1:0] per_in_addr;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    bra_region_dec #(
      .ADDR_W  (ADDR_W),
      .IS_FETCH(s == int'(SRC_FETCH))
    ) u_dec (
      .addr   (src_addr[s]),
      .to_code(to_code[s]),
      .to_sys (to_sys[s]),
      .to_per (to_per[s]),
      .to_err (to_err[s])
    );
    assign per_in_addr[s] = src_addr[s][PER_AW-1:0];
  end

  assign code_req = src_req & to_code;
  assign sys_req  = src_req & to_sys;
  assign per_req  = src_req & to_per;
  assign bad      = src_req & to_err;

  bra_port_arb #(.NSRC(NSRC), .SW(SW), .OUT_AW(ADDR_W),
                 .PRIO({SRC_DEBUG, SRC_FETCH, SRC_DATA})) u_code (
    .clk(clk), .rst(rst), .req(code_req), .addr(src_addr), .ready(code_ready),
    .gnt(code_gnt), .valid(code_valid), .out_addr(code_addr), .out_src(code_src));

  bra_port_arb #(.NSRC(NSRC), .SW(SW), .OUT_AW(ADDR_W),
                 .PRIO({SRC_DEBUG, SRC_FETCH, SRC_DATA})) u_sys (
    .clk(clk), .rst(rst), .req(sys_req), .addr(src_addr), .ready(sys_ready),
    .gnt(sys_gnt), .valid(sys_valid), .out_addr(sys_addr), .out_src(sys_src));

  bra_port_arb #(.NSRC(NSRC), .SW(SW), .OUT_AW(PER_AW),
                 .PRIO({SRC_DEBUG, SRC_FETCH, SRC_DATA})) u_per (
    .clk(clk), .rst(rst), .req(per_req), .addr(per_in_addr), .ready(per_ready),
    .gnt(per_gnt), .valid(per_valid), .out_addr(per_addr), .out_src(per_src));

  bra_err_resp #(.NSRC(NSRC)) u_err (
    .clk(clk), .rst(rst), .bad(bad), .err(src_err));

  assign src_wait = src_req & ~(code_gnt | sys_gnt | per_gnt | bad);

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    assert_err_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      src_req[s] && to_err[s] |=> src_err[s]);
    assert_err_only_bad_R4: assert property (@(posedge clk) disable iff (rst)
      !(src_req[s] && to_err[s]) |=> !src_err[s]);
    assert_single_port_R10: assert property (@(posedge clk) disable iff (rst)
      $countones({code_gnt[s], sys_gnt[s], per_gnt[s]}) <= 1);
  end

  assert_no_fetch_code_R1: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> code_src != SRC_FETCH);
  assert_no_fetch_per_R3: assert property (@(posedge clk) disable iff (rst)
    per_valid |-> per_src != SRC_FETCH);
endmodule

// File: tb/bus_region_arbiter_tb.sv
module bus_region_arbiter_tb;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        src_req = '0;
  logic [2:0][31:0]  src_addr = '0;
  logic [2:0]        src_wait, src_err;
  logic              code_valid, sys_valid, per_valid;
  logic [31:0]       code_addr, sys_addr;
  logic [19:0]       per_addr;
  logic [1:0]        code_src, sys_src, per_src;
  logic              code_ready = 1'b1, sys_ready = 1'b1, per_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_region_arbiter u_dut (
    .clk(clk), .rst(rst), .src_req(src_req), .src_addr(src_addr),
    .src_wait(src_wait), .src_err(src_err),
    .code_valid(code_valid), .code_addr(code_addr), .code_src(code_src), .code_ready(code_ready),
    .sys_valid(sys_valid), .sys_addr(sys_addr), .sys_src(sys_src), .sys_ready(sys_ready),
    .per_valid(per_valid), .per_addr(per_addr), .per_src(per_src), .per_ready(per_ready));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // representative addresses per window class, offset by source
  function automatic logic [31:0] pick_addr(int r, int s);
    case (r)
      0: return 32'h1FFF_FF00 + 32'(s * 4);   // code
      1: return 32'h2000_0000 + 32'(s * 4);   // system low edge
      2: return 32'hE010_0000 + 32'(s * 4);   // system high edge
      3: return 32'hE004_0000 + 32'(s * 4);   // peripheral low edge
      4: return 32'hE00F_FFF0 + 32'(s * 4);   // peripheral high edge
      5: return 32'hE000_0000 + 32'(s * 4);   // unmapped low edge
      default: return 32'hE003_FFF0 + 32'(s * 4); // unmapped high edge
    endcase
  endfunction

  // port: 0 code, 1 system, 2 peripheral, 3 error
  function automatic int port_of(logic [31:0] a, int s);
    if (a < 32'h2000_0000) return (s == 1) ? 3 : 0;
    if (a >= 32'hE000_0000 && a < 32'hE004_0000) return 3;
    if (a >= 32'hE004_0000 && a < 32'hE010_0000) return (s == 1) ? 3 : 2;
    return 1;
  endfunction

  task automatic sweep();
    for (int p = 0; p < 8; p++)
      for (int r0 = 0; r0 < 7; r0++)
        for (int r1 = 0; r1 < 7; r1++)
          for (int r2 = 0; r2 < 7; r2++) begin
            int rr[3];
            int tgt[3];
            int win[3];
            logic [2:0] ew, ee;
            rr[0] = r0; rr[1] = r1; rr[2] = r2;
            @(negedge clk);
            src_req = 3'(p);
            for (int s = 0; s < 3; s++) src_addr[s] = pick_addr(rr[s], s);
            for (int s = 0; s < 3; s++) tgt[s] = port_of(src_addr[s], s);
            for (int q = 0; q < 3; q++) win[q] = -1;
            // lower index wins on every port (data > fetch > debug)
            for (int s = 2; s >= 0; s--)
              if (src_req[s] && tgt[s] < 3) win[tgt[s]] = s;
            for (int s = 0; s < 3; s++) begin
              ew[s] = src_req[s] && tgt[s] < 3 && win[tgt[s]] != s;
              ee[s] = src_req[s] && tgt[s] == 3;
            end
            #1;
            check("R7 R5 R6 wait", 32'(src_wait), 32'(ew));
            @(posedge clk);
            @(negedge clk);
            src_req = '0;
            check("R4 err", 32'(src_err), 32'(ee));
            check("R1 R10 code_valid", 32'(code_valid), 32'(win[0] >= 0));
            check("R2 R10 sys_valid", 32'(sys_valid), 32'(win[1] >= 0));
            check("R3 R10 per_valid", 32'(per_valid), 32'(win[2] >= 0));
            if (win[0] >= 0) begin
              check("R1 R6 code_src", 32'(code_src), 32'(win[0]));
              check("R1 code_addr", code_addr, src_addr[win[0]]);
            end
            if (win[1] >= 0) begin
              check("R2 R5 sys_src", 32'(sys_src), 32'(win[1]));
              check("R2 sys_addr", sys_addr, src_addr[win[1]]);
            end
            if (win[2] >= 0) begin
              check("R3 R6 per_src", 32'(per_src), 32'(win[2]));
              check("R3 per_addr", 32'(per_addr), {12'h0, src_addr[win[2]][19:0]});
            end
          end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 code_valid", 32'(code_valid), 0);
    check("R11 sys_valid", 32'(sys_valid), 0);
    check("R11 per_valid", 32'(per_valid), 0);
    check("R11 err", 32'(src_err), 0);

    sweep();

    // R8 / R7: hold under ready low, debug waits on code port
    @(negedge clk);
    code_ready = 1'b0;
    src_req = 3'b101;
    src_addr[0] = 32'h0000_0100;
    src_addr[2] = 32'h0000_0200;
    #1;
    check("R6 data wins code", 32'(src_wait), 32'b100);
    @(posedge clk);
    @(negedge clk);
    src_req = 3'b100;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R8 valid held", 32'(code_valid), 1);
      check("R8 src held", 32'(code_src), 0);
      check("R8 addr held", code_addr, 32'h0000_0100);
      check("R7 debug waits", 32'(src_wait), 32'b100);
      @(posedge clk);
      @(negedge clk);
    end
    code_ready = 1'b1;
    #1;
    check("R9 accept at handshake", 32'(src_wait), 0);
    @(posedge clk);
    @(negedge clk);
    src_req = '0;
    check("R9 debug on code", 32'(code_src), 2);
    check("R9 debug addr", code_addr, 32'h0000_0200);
    @(posedge clk);
    @(negedge clk);
    check("R9 port idle", 32'(code_valid), 0);

    // R12: data stream starves debug on the system port
    src_addr[2] = 32'h3000_0000;
    for (int k = 0; k < 20; k++) begin
      src_req = 3'b101;
      src_addr[0] = 32'h2000_1000 + 32'(k * 4);
      #1;
      check("R12 debug starved", 32'(src_wait), 32'b100);
      @(posedge clk);
      @(negedge clk);
      check("R12 data back to back", sys_addr, 32'h2000_1000 + 32'(k * 4));
    end
    src_req = 3'b100;
    #1;
    check("R12 debug released", 32'(src_wait), 0);
    @(posedge clk);
    @(negedge clk);
    src_req = '0;
    check("R12 debug on sys", 32'(sys_src), 2);
    check("R12 debug addr", sys_addr, 32'h3000_0000);
    @(posedge clk);
    @(negedge clk);
    check("R4 no stale err", 32'(src_err), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule